// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides, for each incoming frame, whether it is kept or dropped, using only the 48-bit destination address. Software programs up to sixteen station addresses, a bitmap that switches individual addresses on or off, and a small policy word. All of this is done through a plain 32-bit register bus with a combinational read port.

The frame parser presents the destination address with a one-cycle strobe. One cycle later the filter returns a registered verdict. The verdict is an accept flag, a flag saying whether any enabled address matched, and the number of the lowest matching address. The policy word can accept whole classes of traffic (unicast, multicast, broadcast) no matter what is programmed. It can also enable exact-address comparison and turn that comparison into an exclusion list by inverting its result.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, every register reads zero and every frame is rejected with the hit flag low and index 0.
- R2: The policy word at offset 0x00 reads back bits 4:0 and reads zero above them. The enable bitmap at 0x04 reads back bits 15:0. Address slot n has a high word at 0x08+8n that reads back all 32 bits, and a low word at 0x0C+8n that reads back bits 31:16 with bits 15:0 reading zero.
- R3: Destination byte 0 is frm_dst[47:40] and byte 5 is frm_dst[7:0]. Slot n matches when its high word equals bytes 0..3 (byte 0 in bits 31:24) and low-word bits 31:16 equal bytes 4..5 (byte 4 in bits 31:24).
- R4: A slot whose enable bit (bit n of 0x04) is clear never matches.
- R5: Exact-address comparison affects the verdict only while policy bit 4 is set.
- R6: With policy bit 3 set, the comparison result is inverted: a matching frame is not accepted by comparison, and a non-matching frame is.
- R7: An all-ones address is broadcast and is accepted when policy bit 2 is set. An address that is not all ones and has frm_dst[40] set is multicast and is accepted when bit 1 is set. Every other address is unicast and is accepted when bit 0 is set.
- R8: Each strobe on frm_valid yields exactly one acc_valid pulse on the following cycle, including back-to-back strobes.
- R9: When several enabled slots match, acc_index reports the lowest-numbered one. With no match, acc_hit is low and acc_index is 0.
- R10: Writes to offsets outside the map, or to offsets with bits 1:0 non-zero, change nothing, and such offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| frm_valid | input | 1 | Destination address strobe |
| frm_dst | input | 48 | Destination address, byte 0 in the top bits |
| acc_valid | output | 1 | Verdict valid, one cycle after frm_valid |
| acc_accept | output | 1 | Frame accepted |
| acc_hit | output | 1 | Some enabled slot matched |
| acc_index | output | 4 | Lowest matching slot number |

## Verification
The bound checker watches the following on every cycle: the one-to-one timing between strobes and verdict pulses, the reject-all behaviour of an all-zero policy, and acceptance of broadcasts whenever bit 2 is set. It also checks that no hit appears with an empty enable bitmap, that the index is zero on a miss, and that under comparison with inversion alone the accept flag is the opposite of the hit flag. The bench scenarios are needed for the parts that depend on programmed contents. These are the byte packing of the two words, the masking of unused low-word bits, lowest-index priority among duplicate slots, class acceptance for multicast and unicast, and the immunity of the map to stray or misaligned writes.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int CMD_W      = 5;
  localparam int BIT_UCAST  = 0;
  localparam int BIT_MCAST  = 1;
  localparam int BIT_BCAST  = 2;
  localparam int BIT_INVERT = 3;
  localparam int BIT_CMPEN  = 4;
  localparam int MAC_W      = 48;
  localparam int HI_W       = 32;
  localparam int LO_W       = 16;

  typedef enum logic [1:0] {
    CLS_UCAST = 2'd0,
    CLS_MCAST = 2'd1,
    CLS_BCAST = 2'd2
  } addr_class_e;
endpackage

// File: rtl/daf_regfile.sv
module daf_regfile
  import daf_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_write,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic [CMD_W-1:0]       cmd_q,
  output logic [NUM_ENTRIES-1:0] en_q,
  output logic [HI_W-1:0]        hi_q [NUM_ENTRIES],
  output logic [LO_W-1:0]        lo_q [NUM_ENTRIES]
);
  localparam int WORD_W    = ADDR_W - 2;
  localparam int LAST_WORD = 2 + 2 * NUM_ENTRIES - 1;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              wr;
  logic              cmd_we, en_we;
  logic [NUM_ENTRIES-1:0] hi_we, lo_we;

  logic [CMD_W-1:0]       cmd_d;
  logic [NUM_ENTRIES-1:0] en_d;

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr      = bus_sel & bus_write & aligned;
  assign cmd_we  = wr & (word == WORD_W'(0));
  assign en_we   = wr & (word == WORD_W'(1));
  assign cmd_d   = bus_wdata[CMD_W-1:0];
  assign en_d    = bus_wdata[NUM_ENTRIES-1:0];

  genvar g;
  generate
    for (g = 0; g < NUM_ENTRIES; g++) begin : g_slot
      assign hi_we[g] = wr & (word == WORD_W'(2 + 2 * g));
      assign lo_we[g] = wr & (word == WORD_W'(3 + 2 * g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hi_q[g] <= '0;
          lo_q[g] <= '0;
        end else begin
          if (hi_we[g]) hi_q[g] <= bus_wdata;
          if (lo_we[g]) lo_q[g] <= bus_wdata[31:16];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      en_q  <= '0;
    end else begin
      if (cmd_we) cmd_q <= cmd_d;
      if (en_we)  en_q  <= en_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (word == WORD_W'(0)) begin
        bus_rdata[CMD_W-1:0] = cmd_q;
      end else if (word == WORD_W'(1)) begin
        bus_rdata[NUM_ENTRIES-1:0] = en_q;
      end else if (int'(word) <= LAST_WORD) begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
          if (word == WORD_W'(2 + 2 * i)) bus_rdata = hi_q[i];
          if (word == WORD_W'(3 + 2 * i)) bus_rdata = {lo_q[i], 16'h0000};
        end
      end
    end
  end
endmodule

// File: rtl/daf_matcher.sv
module daf_matcher
  import daf_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic [MAC_W-1:0]       dst,
  input  logic [NUM_ENTRIES-1:0] en,
  input  logic [HI_W-1:0]        hi [NUM_ENTRIES],
  input  logic [LO_W-1:0]        lo [NUM_ENTRIES],
  output logic                   hit,
  output logic [IDX_W-1:0]       idx
);
  logic [NUM_ENTRIES-1:0] match_vec;

  genvar g;
  generate
    for (g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
      assign match_vec[g] = en[g] & ({hi[g], lo[g]} == dst);
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/daf_policy.sv
module daf_policy
  import daf_pkg::*;
(
  input  logic [MAC_W-1:0] dst,
  input  logic [CMD_W-1:0] cmd,
  input  logic             hit,
  output logic             accept
);
  addr_class_e cls;
  logic        cmp_term, class_term;

  always_comb begin
    if (&dst)          cls = CLS_BCAST;
    else if (dst[40])  cls = CLS_MCAST;
    else               cls = CLS_UCAST;
  end

  always_comb begin
    cmp_term = cmd[BIT_CMPEN] & (hit ^ cmd[BIT_INVERT]);
    unique case (cls)
      CLS_BCAST: class_term = cmd[BIT_BCAST];
      CLS_MCAST: class_term = cmd[BIT_MCAST];
      default:   class_term = cmd[BIT_UCAST];
    endcase
    accept = cmp_term | class_term;
  end
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
  import daf_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 8,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              frm_valid,
  input  logic [47:0]       frm_dst,
  output logic              acc_valid,
  output logic              acc_accept,
  output logic              acc_hit,
  output logic [IDX_W-1:0]  acc_index
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic [CMD_W-1:0]       cmd_q;
  logic [NUM_ENTRIES-1:0] en_q;
  logic [HI_W-1:0]        hi_q [NUM_ENTRIES];
  logic [LO_W-1:0]        lo_q [NUM_ENTRIES];

  daf_regfile #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n),
    .bus_sel(bus_sel), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmd_q(cmd_q), .en_q(en_q), .hi_q(hi_q), .lo_q(lo_q)
  );

  logic             hit_c;
  logic [IDX_W-1:0] idx_c;
  logic             accept_c;

  daf_matcher #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
    .dst(frm_dst), .en(en_q), .hi(hi_q), .lo(lo_q),
    .hit(hit_c), .idx(idx_c)
  );

  daf_policy u_policy (
    .dst(frm_dst), .cmd(cmd_q), .hit(hit_c), .accept(accept_c)
  );

  logic             valid_d;
  logic             accept_d, hit_d;
  logic [IDX_W-1:0] index_d;

  always_comb begin
    valid_d  = frm_valid;
    accept_d = accept_c;
    hit_d    = hit_c;
    index_d  = idx_c;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      acc_valid <= 1'b0;
    end else begin
      acc_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      acc_accept <= 1'b0;
      acc_hit    <= 1'b0;
      acc_index  <= '0;
    end else if (frm_valid) begin
      acc_accept <= accept_d;
      acc_hit    <= hit_d;
      acc_index  <= index_d;
    end
  end
endmodule

// File: rtl/daf_checker.sv
module daf_checker
  import daf_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input logic                   clk,
  input logic                   rst_core_n,
  input logic                   frm_valid,
  input logic [47:0]            frm_dst,
  input logic [CMD_W-1:0]       cmd,
  input logic [NUM_ENTRIES-1:0] en,
  input logic                   acc_valid,
  input logic                   acc_accept,
  input logic                   acc_hit,
  input logic [IDX_W-1:0]       acc_index
);
  p_verdict_follows_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    frm_valid |=> acc_valid);

  p_no_stray_verdict_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    !frm_valid |=> !acc_valid);

  p_zero_policy_rejects_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (frm_valid && cmd == '0) |=> !acc_accept);

  p_bcast_accepted_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (frm_valid && (&frm_dst) && cmd[BIT_BCAST]) |=> acc_accept);

  p_no_hit_when_disabled_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (frm_valid && en == '0) |=> !acc_hit);

  p_miss_index_zero_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (acc_valid && !acc_hit) |-> (acc_index == '0));

  p_invert_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (frm_valid && cmd == 5'b11000) |=> (acc_accept == !acc_hit));
endmodule

bind dst_addr_filter daf_checker #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .frm_valid(frm_valid), .frm_dst(frm_dst),
  .cmd(cmd_q), .en(en_q), .acc_valid(acc_valid), .acc_accept(acc_accept),
  .acc_hit(acc_hit), .acc_index(acc_index)
);

// File: tb/dst_addr_filter_bench.sv
`timescale 1ns/1ps
module dst_addr_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_write;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        frm_valid;
  logic [47:0] frm_dst;
  logic        acc_valid, acc_accept, acc_hit;
  logic [3:0]  acc_index;

  always #2 clk = ~clk;

  dst_addr_filter u_dst_addr_filter (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frm_valid(frm_valid), .frm_dst(frm_dst), .acc_valid(acc_valid),
    .acc_accept(acc_accept), .acc_hit(acc_hit), .acc_index(acc_index)
  );

  typedef struct {
    bit    acc;
    bit    hit;
    int    idx;
    int    cyc;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0, cyc = 0;
  bit   done = 0;

  logic [4:0]  sh_cmd;
  logic [15:0] sh_en;
  logic [31:0] sh_hi [16];
  logic [15:0] sh_lo [16];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_sel = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    if (a == 8'h00) sh_cmd = d[4:0];
    else if (a == 8'h04) sh_en = d[15:0];
    else if (a[1:0] == 2'b00 && a >= 8'h08 && a <= 8'h84) begin
      if (a[2] == 1'b0) sh_hi[(a - 8'h08) >> 3] = d;
      else              sh_lo[(a - 8'h0C) >> 3] = d[31:16];
    end
    @(negedge clk); #1;
    bus_sel = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #1;
    bus_sel = 1; bus_write = 0; bus_addr = a;
    #0.5;
    check(bus_rdata === exp, tag, bus_rdata, exp);
    bus_sel = 0;
  endtask

  function automatic exp_t model(input logic [47:0] d, input string tag);
    exp_t e;
    bit bc, mc, uc, cmp;
    e.hit = 0; e.idx = 0; e.tag = tag;
    for (int i = 15; i >= 0; i--)
      if (sh_en[i] && sh_hi[i] == d[47:16] && sh_lo[i] == d[15:0]) begin
        e.hit = 1; e.idx = i;
      end
    bc = (d == 48'hFFFF_FFFF_FFFF);
    mc = !bc && d[40];
    uc = !d[40];
    cmp = sh_cmd[4] && (e.hit ^ sh_cmd[3]);
    e.acc = cmp || (uc && sh_cmd[0]) || (mc && sh_cmd[1]) || (bc && sh_cmd[2]);
    return e;
  endfunction

  task automatic send(input logic [47:0] d, input string tag);
    exp_t e;
    @(negedge clk); #1;
    frm_valid = 1; frm_dst = d;
    e = model(d, tag);
    e.cyc = cyc;
    q.push_back(e);
  endtask

  task automatic quiet();
    @(negedge clk); #1;
    frm_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic one(input logic [47:0] d, input string tag);
    send(d, tag);
    quiet();
  endtask

  // Monitor: pops expected verdicts as the design produces them
  always @(negedge clk) begin
    if (rst_n && acc_valid) begin
      if (q.size() == 0) begin
        check(0, "R8 unexpected verdict", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(cyc == e.cyc + 1, {e.tag, " R8 latency"}, cyc, e.cyc + 1);
        check(acc_accept == e.acc, {e.tag, " accept"}, acc_accept, e.acc);
        check(acc_hit == e.hit, {e.tag, " hit"}, acc_hit, e.hit);
        check(acc_index == e.idx[3:0], {e.tag, " index"}, acc_index, e.idx);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  localparam logic [47:0] MAC_A = 48'h02_11_22_33_44_55;
  localparam logic [47:0] MAC_B = 48'h02_11_22_33_44_56;
  localparam logic [47:0] MAC_C = 48'h0A_BC_DE_F0_12_34;
  localparam logic [47:0] MCAST = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  initial begin
    rst_n = 0; bus_sel = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
    frm_valid = 0; frm_dst = 0;
    sh_cmd = 0; sh_en = 0;
    for (int i = 0; i < 16; i++) begin sh_hi[i] = 0; sh_lo[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(8'h00, 32'h0, "R1 policy reset");
    rd(8'h04, 32'h0, "R1 enable reset");
    rd(8'h08, 32'h0, "R1 slot0 high reset");
    one(BCAST, "R1 bcast after reset");
    one(MAC_A, "R1 ucast after reset");

    // R2/R3: program slot 3 with MAC_A, low word junk in 15:0
    wr(8'h08 + 8*3, 32'h0211_2233);
    wr(8'h0C + 8*3, 32'h4455_FFFF);
    wr(8'h04, 32'hFFFF_0008);
    wr(8'h00, 32'hFFFF_FFF0);
    rd(8'h00, 32'h0000_0010, "R2 policy readback");
    rd(8'h04, 32'h0000_0008, "R2 enable readback");
    rd(8'h08 + 8*3, 32'h0211_2233, "R2 high readback");
    rd(8'h0C + 8*3, 32'h4455_0000, "R2 low readback masked");
    one(MAC_A, "R3 exact match slot3");
    one(MAC_B, "R3 last byte differs");

    // R4: disable slot 3
    wr(8'h04, 32'h0000_0000);
    one(MAC_A, "R4 disabled slot");
    wr(8'h04, 32'h0000_0008);

    // R5: comparison off
    wr(8'h00, 32'h0000_0000);
    one(MAC_A, "R5 compare off");

    // R6: inverted comparison
    wr(8'h00, 32'h0000_0018);
    one(MAC_A, "R6 invert on match");
    one(MAC_C, "R6 invert on miss");

    // R9: duplicates in slots 5 and 9, plus slot 15
    wr(8'h00, 32'h0000_0010);
    wr(8'h08 + 8*5, 32'h0ABC_DEF0);  wr(8'h0C + 8*5, 32'h1234_0000);
    wr(8'h08 + 8*9, 32'h0ABC_DEF0);  wr(8'h0C + 8*9, 32'h1234_0000);
    wr(8'h08 + 8*15, 32'h0102_0304); wr(8'h0C + 8*15, 32'h0506_0000);
    wr(8'h04, 32'h0000_8228);
    one(MAC_C, "R9 lowest of 5 and 9");
    wr(8'h04, 32'h0000_8208);
    one(MAC_C, "R9 only slot 9");
    one(48'h01_02_03_04_05_06, "R9 slot 15");

    // R7: class acceptance
    wr(8'h04, 32'h0);
    wr(8'h00, 32'h0000_0004);
    one(BCAST, "R7 bcast bit2");
    one(MCAST, "R7 mcast with bit2 only");
    one(MAC_A, "R7 ucast with bit2 only");
    wr(8'h00, 32'h0000_0002);
    one(MCAST, "R7 mcast bit1");
    one(BCAST, "R7 bcast with bit1 only");
    wr(8'h00, 32'h0000_0001);
    one(MAC_C, "R7 ucast bit0");
    one(MCAST, "R7 mcast with bit0 only");

    // R8: back-to-back strobes
    wr(8'h04, 32'h0000_0228);
    wr(8'h00, 32'h0000_0014);
    send(MAC_A, "R8 b2b first");
    send(BCAST, "R8 b2b second");
    send(MAC_C, "R8 b2b third");
    send(MCAST, "R8 b2b fourth");
    quiet();

    // R10: unmapped and misaligned writes
    wr(8'h88, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    wr(8'h0A + 8*3, 32'hDEAD_BEEF);
    rd(8'h88, 32'h0, "R10 unmapped reads zero");
    rd(8'h01, 32'h0, "R10 misaligned reads zero");
    rd(8'h00, 32'h0000_0014, "R10 policy untouched");
    rd(8'h04, 32'h0000_0228, "R10 enable untouched");
    rd(8'h08 + 8*3, 32'h0211_2233, "R10 slot3 untouched");
    one(MAC_A, "R10 match after stray writes");

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R8 outstanding verdicts", q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule